// File: doc/BRIEF.md
# Programmable interrupt redirection controller

The controller routes up to 24 external interrupt lines to processor cores by sending interrupt messages. Each line has a 64-bit redirection entry. The entry holds the vector, the delivery mode, the destination (a physical ID or a logical mask), the input polarity, the trigger mode and a mask. The block detects edge-type and level-type interrupts. It tracks for each entry whether a message is waiting and whether a level interrupt is still unacknowledged, and it sends messages on a single valid/ready port. When an end-of-interrupt notice arrives, every in-service level entry whose vector matches is released.

Software reaches the registers indirectly. A write to the select port stores a register index. The window port then reads or writes the 32-bit register named by that index. Index 0x00 is the identification register. Indices 0x10 to 0x3F form the redirection table, and each entry takes two indices.

Top module: `irq_route_ctrl`

## Requirements
- R1: With `bus_win`=0, a write stores `bus_wdata[7:0]` as the select index, and a read returns that index zero-extended. With `bus_win`=1, the access goes to the register named by the select index.
- R2: Register 0x00 holds a 4-bit ID in bits 27:24, which resets to 0. All other bits of that register read 0, and writes to them have no effect.
- R3: Entry n (0 to 23) has its low word at index 0x10+2n and its high word at index 0x11+2n. Low-word fields: vector [7:0], delivery mode [10:8], logical destination [11], active-low polarity [13], level trigger [15], mask [16]. High-word field: destination [31:24]. All other bits, and every index that is not implemented, read 0.
- R4: Low-word bit 12 (delivery status) and bit 14 (remote IRR) are read-only, and writes to those bits are ignored.
- R5: Delivery status reads 1 from the clock edge that detects an interrupt until the edge at which its message is accepted (`msg_valid` and `msg_ready` both high). It reads 0 after that edge.
- R6: The input is XORed with the polarity bit. An edge-type entry fires once on each transition from inactive to active. A line held active does not produce a second message.
- R7: A level-type entry fires while its input is active and remote IRR is 0. Remote IRR is set when the message is accepted. It is cleared by an end-of-interrupt notice with a matching vector, and a non-matching vector leaves it set. If the line is still active, the entry fires again one edge after the clear.
- R8: Delivery modes 4, 5 and 7 are handled as edge-triggered, even when the trigger bit is 1. For these entries `msg_level` reads 0 and remote IRR is never set.
- R9: After reset every entry is masked and all its other fields are 0. A masked entry detects nothing, and an edge that occurs while the entry is masked is discarded.
- R10: When several entries are pending, the one with the lowest entry number is offered first.
- R11: While `msg_valid` is high and `msg_ready` is low, the offered entry does not change, even if a lower-numbered entry becomes pending. The message carries the vector, delivery mode, logical flag, destination and effective trigger mode.
- R12: An entry whose delivery mode is one of the reserved codes 3 or 6 never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_win | input | 1 | 0 selects the index register, 1 selects the data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_in | input | 24 | Interrupt lines, synchronous to clk |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The receiver accepts the offered message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Destination is a logical mask |
| msg_dest | output | 8 | Destination |
| msg_level | output | 1 | Effective trigger mode is level |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt notice |

## Verification
An interrupt edge or an active level that is present before clock edge k makes `msg_valid` high right after edge k. Accepting the message at edge m clears delivery status and sets remote IRR at m. An end-of-interrupt notice at edge e clears remote IRR at e, and a level entry whose line is still active fires again at e+1. The bench drives every input 1 ns after a rising edge and samples outputs after those inputs have settled, so each check lands on the cycle it names. Register reads are combinational once the select write has taken effect at its edge. Register contents are also exercised with seeded random words whose expected readback is computed from the writable-field masks.

// File: rtl/irq_route_pkg.sv
// Shared types and helpers for the interrupt redirection controller.
// Assumes: table entries occupy two consecutive 32-bit register indices.
package irq_route_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned IDX_W  = 8;
    localparam int unsigned VEC_W  = 8;
    localparam int unsigned DEST_W = 8;
    localparam int unsigned MAX_SRC = 24;
    localparam logic [IDX_W-1:0] ID_INDEX   = 8'h00;
    localparam logic [IDX_W-1:0] TABLE_BASE = 8'h10;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD3  = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_RSVD6  = 3'd6,
        DM_EXTINT = 3'd7
    } dmode_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              level;
        logic              active_low;
        logic              logical;
        dmode_e            mode;
        logic [VEC_W-1:0]  vector;
    } entry_cfg_t;

    localparam entry_cfg_t ENTRY_RESET = '{
        dest: '0, mask: 1'b1, level: 1'b0, active_low: 1'b0,
        logical: 1'b0, mode: DM_FIXED, vector: '0
    };

    // Modes that are always handled as edge-triggered.
    function automatic logic forces_edge(dmode_e m);
        return (m == DM_NMI) || (m == DM_INIT) || (m == DM_EXTINT);
    endfunction

    // Reserved delivery-mode codes.
    function automatic logic is_reserved(dmode_e m);
        return (m == DM_RSVD3) || (m == DM_RSVD6);
    endfunction

    // Low register word of an entry including the read-only status bits.
    function automatic logic [REG_W-1:0] low_word(entry_cfg_t c, logic busy, logic rirr);
        return {15'b0, c.mask, c.level, rirr, c.active_low, busy,
                c.logical, 3'(c.mode), c.vector};
    endfunction

    // High register word of an entry.
    function automatic logic [REG_W-1:0] high_word(entry_cfg_t c);
        return {c.dest, 24'b0};
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
// Indirect register file: select index plus a 32-bit data window onto the
// identification register and the redirection table.
// Assumes: TABLE_BASE is even, so bit 0 of the table offset picks the half.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 24,
    parameter logic [3:0]  ID_RESET = 4'h0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic                    bus_win,
    input  logic [REG_W-1:0]        bus_wdata,
    output logic [REG_W-1:0]        bus_rdata,
    input  logic [NUM_SRC-1:0]      busy,
    input  logic [NUM_SRC-1:0]      rirr,
    output entry_cfg_t [NUM_SRC-1:0] cfg
);

    localparam int unsigned ENT_W = IDX_W - 1;
    localparam logic [IDX_W-1:0] TABLE_END = IDX_W'(int'(TABLE_BASE) + 2 * NUM_SRC);

    logic [IDX_W-1:0] sel_q;
    logic [3:0]       id_q;
    entry_cfg_t [NUM_SRC-1:0] cfg_q;

    logic             hit_id;
    logic             hit_tbl;
    logic [IDX_W-1:0] slot;
    logic [ENT_W-1:0] ent_idx;
    logic             hi_half;
    logic [REG_W-1:0] win_rd;
    logic             win_wr;
    logic [6:0]       unused_wbits;

    assign hit_id   = (sel_q == ID_INDEX);
    assign hit_tbl  = (sel_q >= TABLE_BASE) && (sel_q < TABLE_END);
    assign slot     = sel_q - TABLE_BASE;
    assign ent_idx  = slot[IDX_W-1:1];
    assign hi_half  = slot[0];
    assign win_wr   = bus_we && bus_win;
    assign unused_wbits = bus_wdata[23:17];
    assign cfg      = cfg_q;

    // Select register: captures the index written through the select port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (bus_we && !bus_win)
            sel_q <= bus_wdata[IDX_W-1:0];
    end

    // Identification register: only the 4-bit ID field is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_q <= ID_RESET;
        else if (win_wr && hit_id)
            id_q <= bus_wdata[27:24];
    end

    // Redirection table storage: writable fields of the addressed half only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++)
                cfg_q[i] <= ENTRY_RESET;
        end else if (win_wr && hit_tbl) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (ent_idx == ENT_W'(i)) begin
                    if (hi_half) begin
                        cfg_q[i].dest <= bus_wdata[31:24];
                    end else begin
                        cfg_q[i].vector     <= bus_wdata[7:0];
                        cfg_q[i].mode       <= dmode_e'(bus_wdata[10:8]);
                        cfg_q[i].logical    <= bus_wdata[11];
                        cfg_q[i].active_low <= bus_wdata[13];
                        cfg_q[i].level      <= bus_wdata[15];
                        cfg_q[i].mask       <= bus_wdata[16];
                    end
                end
            end
        end
    end

    // Window read mux: identification, table halves, or zero.
    always_comb begin
        win_rd = '0;
        if (hit_id) begin
            win_rd = {4'b0, id_q, 24'b0};
        end else if (hit_tbl) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (ent_idx == ENT_W'(i))
                    win_rd = hi_half ? high_word(cfg_q[i])
                                     : low_word(cfg_q[i], busy[i], rirr[i]);
            end
        end
    end

    // Port read: window contents or the select index.
    assign bus_rdata = bus_win ? win_rd : REG_W'(sel_q);

    // R2: reserved bits of the identification register always read zero.
    p_id_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_id |-> (win_rd[23:0] == '0) && (win_rd[31:28] == '0));

endmodule

// File: rtl/irq_route_src.sv
// Per-line detector: polarity, edge/level detection, pending (delivery
// status) and remote IRR tracking.
// Assumes: irq_raw is already synchronous to clk.
module irq_route_src
    import irq_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_raw,
    input  logic [VEC_W-1:0] vector,
    input  dmode_e           mode,
    input  logic             active_low,
    input  logic             level,
    input  logic             mask,
    input  logic             accept,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    output logic             pending,
    output logic             rirr,
    output logic             level_eff
);

    logic active;
    logic prev_q;
    logic pend_q;
    logic rirr_q;
    logic armed;
    logic fire;
    logic eoi_hit;

    assign active    = irq_raw ^ active_low;
    assign level_eff = level && !forces_edge(mode);
    assign armed     = !mask && !is_reserved(mode);
    assign fire      = armed && (level_eff ? (active && !rirr_q && !pend_q)
                                           : (active && !prev_q));
    assign eoi_hit   = eoi_valid && (eoi_vector == vector);
    assign pending   = pend_q;
    assign rirr      = rirr_q;

    // Previous active level, for edge detection (tracks even while masked).
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= active;
    end

    // Delivery status: set on detection, cleared on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= fire || (pend_q && !accept);
    end

    // Remote IRR: set on level acceptance, cleared by a matching notice.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rirr_q <= 1'b0;
        else if (accept && level_eff)
            rirr_q <= 1'b1;
        else if (eoi_hit)
            rirr_q <= 1'b0;
    end

    // R7: remote IRR only rises from an accepted message.
    p_rirr_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rirr_q) |-> $past(accept));

    // R7: a matching notice with no concurrent acceptance releases the entry.
    p_eoi_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && !accept && rirr_q) |=> !rirr_q);

    // R9: a masked entry never becomes pending.
    p_mask_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> !$past(mask));

    // R12: reserved modes never become pending.
    p_rsvd_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> !is_reserved($past(mode)));

endmodule

// File: rtl/irq_route_arb.sv
// Output selector: lowest pending entry first, held steady while the
// receiver stalls.
// Assumes: a pending bit only clears through its own acceptance.
module irq_route_arb #(
    parameter int unsigned NUM_SRC = 24,
    localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pending,
    input  logic               msg_ready,
    output logic               msg_valid,
    output logic [SEL_W-1:0]   grant_idx,
    output logic [NUM_SRC-1:0] accept
);

    logic             held_q;
    logic [SEL_W-1:0] held_idx_q;
    logic [SEL_W-1:0] low_idx;

    // Lowest-numbered pending entry.
    always_comb begin
        low_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--)
            if (pending[i]) low_idx = SEL_W'(i);
    end

    assign msg_valid = |pending;
    assign grant_idx = held_q ? held_idx_q : low_idx;

    // One-hot acceptance toward the granted entry.
    always_comb begin
        accept = '0;
        for (int i = 0; i < NUM_SRC; i++)
            accept[i] = msg_valid && msg_ready && (grant_idx == SEL_W'(i));
    end

    // Hold register: remembers a stalled grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q     <= 1'b0;
            held_idx_q <= '0;
        end else begin
            held_q     <= msg_valid && !msg_ready;
            held_idx_q <= grant_idx;
        end
    end

    // R11: a stalled offer keeps its entry.
    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && grant_idx == $past(grant_idx)));

    // R10: a fresh grant has no lower pending entry.
    p_lowest_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !held_q) |-> ((pending & ((NUM_SRC'(1) << grant_idx) - NUM_SRC'(1))) == '0));

    // R11: at most one entry is accepted per cycle.
    p_accept_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(accept));

endmodule

// File: rtl/irq_route_ctrl.sv
// Top of the interrupt redirection controller: register window, one
// detector per line, and the single message port.
// Assumes: NUM_SRC between 2 and 24; all inputs synchronous to clk.
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 24,
    parameter logic [3:0]  ID_RESET = 4'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic               bus_win,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [7:0]         msg_vector,
    output logic [2:0]         msg_mode,
    output logic               msg_logical,
    output logic [7:0]         msg_dest,
    output logic               msg_level,
    input  logic               eoi_valid,
    input  logic [7:0]         eoi_vector
);

    localparam int unsigned SEL_W = $clog2(NUM_SRC);

    entry_cfg_t [NUM_SRC-1:0] cfg;
    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] rirr;
    logic [NUM_SRC-1:0] level_eff;
    logic [NUM_SRC-1:0] accept;
    logic [SEL_W-1:0]   grant_idx;

    irq_route_regs #(
        .NUM_SRC  (NUM_SRC),
        .ID_RESET (ID_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_win   (bus_win),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (pending),
        .rirr      (rirr),
        .cfg       (cfg)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_route_src u_src (
            .clk        (clk),
            .rst_n      (rst_n),
            .irq_raw    (irq_in[g]),
            .vector     (cfg[g].vector),
            .mode       (cfg[g].mode),
            .active_low (cfg[g].active_low),
            .level      (cfg[g].level),
            .mask       (cfg[g].mask),
            .accept     (accept[g]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .pending    (pending[g]),
            .rirr       (rirr[g]),
            .level_eff  (level_eff[g])
        );
    end

    irq_route_arb #(
        .NUM_SRC (NUM_SRC)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .grant_idx (grant_idx),
        .accept    (accept)
    );

    // Message fields from the granted entry.
    always_comb begin
        msg_vector  = cfg[grant_idx].vector;
        msg_mode    = 3'(cfg[grant_idx].mode);
        msg_logical = cfg[grant_idx].logical;
        msg_dest    = cfg[grant_idx].dest;
        msg_level   = level_eff[grant_idx];
    end

    // R8: forced-edge modes never present a level message.
    p_forced_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_mode == 3'd4 || msg_mode == 3'd5 || msg_mode == 3'd7)) |-> !msg_level);

endmodule

// File: tb/irq_route_ctrl_bench.sv
`timescale 1ns/1ps
module irq_route_ctrl_bench;

    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_win = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_mode;
    logic        msg_logical;
    logic [7:0]  msg_dest;
    logic        msg_level;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_route_ctrl #(.NUM_SRC(N)) u_irq_route_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_win(bus_win),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_logical(msg_logical), .msg_dest(msg_dest),
        .msg_level(msg_level), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic win, input logic [31:0] d);
        bus_we = 1'b1; bus_win = win; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
        bus_write(1'b0, {24'b0, idx});
        bus_write(1'b1, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [31:0] v);
        bus_write(1'b0, {24'b0, idx});
        bus_win = 1'b1;
        #1;
        v = bus_rdata;
    endtask

    task automatic accept_one();
        msg_ready = 1'b1;
        step();
        msg_ready = 1'b0;
    endtask

    task automatic send_eoi(input logic [7:0] v);
        eoi_valid = 1'b1; eoi_vector = v;
        step();
        eoi_valid = 1'b0;
    endtask

    // Low word built from fields (positions from R3).
    function automatic logic [31:0] mk_low(input logic [7:0] vec, input logic [2:0] mode,
                                           input logic logical, input logic pol,
                                           input logic lvl, input logic msk);
        return {15'b0, msk, lvl, 1'b0, pol, 1'b0, logical, mode, vec};
    endfunction

    function automatic logic [31:0] low_expect(input logic [31:0] w);
        return w & 32'h0001_AFFF;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        repeat (4) step();
        rst_n = 1'b1;
        step();

        // R9 reset state, R3 layout
        reg_read(8'h10, rd); check("R9", "entry0 low after reset", rd, 32'h0001_0000);
        reg_read(8'h11, rd); check("R9", "entry0 high after reset", rd, 32'h0);
        check("R9", "no message after reset", {31'b0, msg_valid}, 32'h0);
        // R1 select readback
        bus_write(1'b0, 32'h0000_0033); bus_win = 1'b0; #1;
        check("R1", "select readback", bus_rdata, 32'h33);
        // R2 identification
        reg_read(8'h00, rd); check("R2", "ID reset", rd, 32'h0);
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_read(8'h00, rd); check("R2", "ID reserved bits", rd, 32'h0F00_0000);
        // R3 unimplemented index
        reg_write(8'h40, 32'hFFFF_FFFF);
        reg_read(8'h40, rd); check("R3", "index 0x40 reads zero", rd, 32'h0);
        reg_read(8'h05, rd); check("R3", "index 0x05 reads zero", rd, 32'h0);
        // R4 read-only status bits on entry 11
        reg_write(8'h26, 32'h0001_5012);
        reg_read(8'h26, rd); check("R4", "status bits ignore writes", rd, 32'h0001_0012);

        // R6/R5/R11 edge entry 3
        reg_write(8'h17, 32'h5A00_0000);
        reg_write(8'h16, mk_low(8'h41, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0));
        irq_in[3] = 1'b1;
        step();
        check("R6", "edge fires", {31'b0, msg_valid}, 32'h1);
        check("R11", "vector", {24'b0, msg_vector}, 32'h41);
        check("R11", "mode", {29'b0, msg_mode}, 32'h1);
        check("R11", "logical", {31'b0, msg_logical}, 32'h1);
        check("R11", "dest", {24'b0, msg_dest}, 32'h5A);
        reg_read(8'h16, rd); check("R5", "status busy", rd, 32'h0000_1941);
        accept_one();
        check("R5", "valid drops after accept", {31'b0, msg_valid}, 32'h0);
        reg_read(8'h16, rd); check("R5", "status idle", rd, 32'h0000_0941);
        step(); step();
        check("R6", "held line no refire", {31'b0, msg_valid}, 32'h0);
        irq_in[3] = 1'b0;

        // R7 level entry 5, active low, line low = active
        reg_write(8'h1A, mk_low(8'h55, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0));
        step();
        check("R7", "level fires", {31'b0, msg_valid}, 32'h1);
        check("R7", "level flag", {31'b0, msg_level}, 32'h1);
        accept_one();
        step();
        check("R7", "no refire while rirr", {31'b0, msg_valid}, 32'h0);
        reg_read(8'h1A, rd); check("R7", "rirr set", rd, 32'h0000_E055);
        send_eoi(8'h56);
        step();
        check("R7", "wrong vector keeps rirr", {31'b0, msg_valid}, 32'h0);
        send_eoi(8'h55);
        check("R7", "no fire on eoi edge", {31'b0, msg_valid}, 32'h0);
        step();
        check("R7", "refire after eoi", {31'b0, msg_valid}, 32'h1);
        irq_in[5] = 1'b1;
        accept_one();
        send_eoi(8'h55);
        step();
        check("R7", "inactive line no refire", {31'b0, msg_valid}, 32'h0);

        // R8 NMI with level bit set, entry 6
        reg_write(8'h1C, mk_low(8'h66, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0));
        irq_in[6] = 1'b1;
        step();
        check("R8", "nmi fires", {31'b0, msg_valid}, 32'h1);
        check("R8", "nmi not level", {31'b0, msg_level}, 32'h0);
        accept_one();
        step();
        check("R8", "nmi no refire", {31'b0, msg_valid}, 32'h0);
        reg_read(8'h1C, rd); check("R8", "nmi rirr clear", rd, 32'h0000_8466);
        irq_in[6] = 1'b0;

        // R9 masked edge discarded, entry 7
        reg_write(8'h1E, mk_low(8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
        irq_in[7] = 1'b1;
        step(); step();
        check("R9", "masked no message", {31'b0, msg_valid}, 32'h0);
        reg_write(8'h1E, mk_low(8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        step(); step();
        check("R9", "edge during mask discarded", {31'b0, msg_valid}, 32'h0);
        irq_in[7] = 1'b0;

        // R12 reserved mode, entry 10
        reg_write(8'h24, mk_low(8'hAA, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0));
        irq_in[10] = 1'b1;
        step(); step();
        check("R12", "reserved mode no message", {31'b0, msg_valid}, 32'h0);
        irq_in[10] = 1'b0;

        // R10/R11 ordering and hold, entries 1, 2, 9
        reg_write(8'h12, mk_low(8'h11, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        reg_write(8'h14, mk_low(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        reg_write(8'h22, mk_low(8'h99, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        irq_in[2] = 1'b1; irq_in[9] = 1'b1;
        step();
        check("R10", "lowest first", {24'b0, msg_vector}, 32'h22);
        accept_one();
        check("R10", "next entry", {24'b0, msg_vector}, 32'h99);
        step();
        irq_in[1] = 1'b1;
        step();
        check("R11", "stalled offer held", {24'b0, msg_vector}, 32'h99);
        accept_one();
        check("R10", "lower entry after release", {24'b0, msg_vector}, 32'h11);
        accept_one();
        check("R10", "all served", {31'b0, msg_valid}, 32'h0);
        irq_in[1] = 1'b0; irq_in[2] = 1'b0; irq_in[9] = 1'b0;

        // R3/R4 seeded random register contents on masked entries 12..23
        for (int k = 0; k < 40; k++) begin
            int unsigned e;
            logic [31:0] lw;
            logic [31:0] hw;
            e  = 12 + $urandom_range(11, 0);
            lw = $urandom() | 32'h0001_0000;
            hw = $urandom();
            reg_write(8'(8'h10 + 2 * e), lw);
            reg_write(8'(8'h11 + 2 * e), hw);
            reg_read(8'(8'h10 + 2 * e), rd);
            check("R3", "random low readback", rd, low_expect(lw));
            reg_read(8'(8'h11 + 2 * e), rd);
            check("R3", "random high readback", rd, hw & 32'hFF00_0000);
        end
        check("R9", "random masked entries silent", {31'b0, msg_valid}, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule